// File: doc/BRIEF.md
# Time-Triggered Bus Frame Receiver

This block turns a recovered, already bit-timed NRZ stream from an automotive time-triggered bus into frame fields. Each accepted bit arrives as a value with a one-cycle valid strobe. The receiver first finds a run of low bits followed by a high start bit. It then drops the two framing bits that come before every byte. From what is left it rebuilds the 40-bit header, streams the payload bytes out one at a time and captures the 24-bit trailer check word. CRC arithmetic is not performed here. The trailer value is only handed on.

After the trailer, the receiver checks the two-bit end marker. It then tells a static frame from a dynamic one. A dynamic frame has a low trailing run that the first high bit ends. The receiver then counts the idle delimiter of high bits before it reports the frame complete. A corrupted start is reported as a collision avoidance symbol. Rule violations and framing faults raise a protocol error. In both cases the receiver drops back to idle, ready for the next start sequence.

Top module: `tt_frame_rx`

## Requirements
- R1: While reset is low, and after it, every output is 0.
- R2: In idle, high bits are ignored. One or more low bits followed by a high bit start a frame, and that high bit is the frame start bit. The next bit after it is treated as the first byte-framing bit.
- R3: Every byte, including the first header byte, is sent as a high bit, then a low bit, then 8 data bits MSB first. The receiver removes the two framing bits. The 40 header data bits are, from first to last: reserved (1), preamble indicator (1), null indicator (1), sync (1), startup (1), frame ID (11), payload words (7), header CRC (11), cycle (6), each MSB first. The fields are presented and `hdr_vld_o` pulses for one cycle after the clock edge that accepts the last header bit. The fields hold until the next accepted header.
- R4: `null_frame_o` is the inverse of the received null indicator: a received 0 gives 1.
- R5: After the header come exactly 2 × payload-words bytes. Each byte appears on `byte_o` with a one-cycle `byte_vld_o`, one cycle after its last data bit. A word count of 0 gives no bytes.
- R6: Three framed bytes after the payload form `frame_crc_o`, with the first byte in bits 23:16. `trl_vld_o` pulses after the last of them.
- R7: If the two bits after the frame start bit are not high then low, `cas_o` pulses. No header is reported and the receiver returns to idle.
- R8: After the trailer a high then a low bit are required. If the next bit is high, the frame is static and that bit is the first of 11 idle-delimiter high bits. `frame_done_o` pulses after the 11th, with `dynamic_o` = 0.
- R9: If the bit after the end marker is low, the frame is dynamic. Low bits continue until a high bit ends the trailing run. Then 11 high bits follow, and `frame_done_o` pulses after the 11th, with `dynamic_o` = 1.
- R10: A header with frame ID 0, or with startup = 1 and sync = 0, raises `proto_err_o` in place of `hdr_vld_o`. The receiver returns to idle.
- R11: A wrong framing-bit value after the first byte, a wrong end marker, or a low bit inside the idle delimiter each raise `proto_err_o`. No completion is reported and the receiver returns to idle.
- R12: After completion or any error, the receiver accepts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld_i | input | 1 | One-cycle strobe: `bit_i` holds a sampled bus bit |
| bit_i | input | 1 | Sampled bus bit, 1 = high |
| hdr_vld_o | output | 1 | Header fields updated |
| rsv_o | output | 1 | Reserved header bit |
| ppi_o | output | 1 | Payload preamble indicator |
| null_frame_o | output | 1 | 1 = null frame |
| sync_o | output | 1 | Sync indicator |
| startup_o | output | 1 | Startup indicator |
| frame_id_o | output | 11 | Frame identifier |
| pay_words_o | output | 7 | Payload length in 16-bit words |
| hdr_crc_o | output | 11 | Received header CRC field |
| cycle_o | output | 6 | Cycle count |
| byte_vld_o | output | 1 | Payload byte strobe |
| byte_o | output | 8 | Payload byte |
| trl_vld_o | output | 1 | Trailer word updated |
| frame_crc_o | output | 24 | Received trailer CRC |
| frame_done_o | output | 1 | Idle delimiter complete |
| dynamic_o | output | 1 | Last completed frame was dynamic |
| cas_o | output | 1 | Collision avoidance symbol seen |
| proto_err_o | output | 1 | Protocol violation, frame dropped |

## Verification
The hardest state to reach is the tail of the frame. The end marker, the trailing-run decision and the exact 11th delimiter bit are only reached after a correctly framed header, payload and trailer have all gone through. So the bench builds complete frames from field values, with every byte framing bit inserted. It then cuts them short or corrupts one bit at a chosen place. This covers a delimiter one bit short, a broken end marker and a low bit inside the delimiter. The same frame builder also reaches the header-rule errors, by stopping right after the fifth header byte.

// File: rtl/frx_pkg.sv
// Shared state types for the frame receiver.
package frx_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_TSS, RX_BYTES, RX_TAIL} rx_state_e;
    typedef enum logic [1:0] {PH_HDR, PH_PAY, PH_TRL} phase_e;
    typedef enum logic [2:0] {TL_FES_HI, TL_FES_LO, TL_DECIDE, TL_DTS, TL_CID} tail_state_e;
endpackage

// File: rtl/frx_bss_strip.sv
// Byte cell de-framer: each cell is a high bit, a low bit and BYTE_W data
// bits. Assumes the caller holds en_i low whenever no byte sequence is in
// flight, which restarts the cell position.
module frx_bss_strip #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              bss_err_o
);
    localparam int CELL  = BYTE_W + 2;
    localparam int CNT_W = $clog2(CELL);

    logic [CNT_W-1:0]  pos_q;
    logic [BYTE_W-2:0] shf_q;
    logic              take;

    // Decode the current bit against its position in the cell.
    always_comb begin
        take        = en_i & bit_vld_i;
        bss_err_o   = take && (((pos_q == '0) && !bit_i) ||
                               ((pos_q == CNT_W'(1)) && bit_i));
        byte_done_o = take && (pos_q == CNT_W'(CELL - 1));
        byte_o      = {shf_q, bit_i};
    end

    // Track position in the cell and gather data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pos_q <= '0;
            shf_q <= '0;
        end else if (take) begin
            if (pos_q == CNT_W'(CELL - 1)) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + CNT_W'(1);
            end
            if (pos_q >= CNT_W'(2)) begin
                shf_q <= byte_o[BYTE_W-2:0];
            end
        end
    end
endmodule

// File: rtl/frx_hdr_unpack.sv
// Splits a complete header word into its fields and flags header rule
// violations. Purely combinational; the first received bit is the MSB.
module frx_hdr_unpack #(
    parameter int ID_W   = 11,
    parameter int LEN_W  = 7,
    parameter int HCRC_W = 11,
    parameter int CYC_W  = 6,
    localparam int HDR_W = 5 + ID_W + LEN_W + HCRC_W + CYC_W
) (
    input  logic [HDR_W-1:0]  hdr_i,
    output logic              rsv_o,
    output logic              ppi_o,
    output logic              nf_o,
    output logic              sync_o,
    output logic              stup_o,
    output logic [ID_W-1:0]   id_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [HCRC_W-1:0] hcrc_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic              rule_err_o
);
    localparam int HCRC_LSB = CYC_W;
    localparam int LEN_LSB  = HCRC_LSB + HCRC_W;
    localparam int ID_LSB   = LEN_LSB + LEN_W;

    // Field slicing and header rule checks.
    always_comb begin
        rsv_o      = hdr_i[HDR_W-1];
        ppi_o      = hdr_i[HDR_W-2];
        nf_o       = hdr_i[HDR_W-3];
        sync_o     = hdr_i[HDR_W-4];
        stup_o     = hdr_i[HDR_W-5];
        id_o       = hdr_i[ID_LSB +: ID_W];
        len_o      = hdr_i[LEN_LSB +: LEN_W];
        hcrc_o     = hdr_i[HCRC_LSB +: HCRC_W];
        cyc_o      = hdr_i[0 +: CYC_W];
        rule_err_o = (id_o == '0) || (stup_o && !sync_o);
    end
endmodule

// File: rtl/frx_tail_seq.sv
// Post-trailer sequencer: end marker (high, low), static/dynamic decision,
// trailing run, and idle delimiter count. Assumes en_i is held low outside
// the tail so every tail starts from the end marker.
module frx_tail_seq #(
    parameter int CID_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic done_o,
    output logic err_o,
    output logic dyn_o
);
    import frx_pkg::*;
    localparam int CW = $clog2(CID_LEN + 1);

    tail_state_e st_q;
    logic [CW-1:0] cid_q;
    logic dyn_q;
    logic take;

    // Flag completion or violation for the bit being accepted.
    always_comb begin
        take   = en_i & bit_vld_i;
        done_o = 1'b0;
        err_o  = 1'b0;
        dyn_o  = dyn_q;
        if (take) begin
            case (st_q)
                TL_FES_HI: err_o  = !bit_i;
                TL_FES_LO: err_o  = bit_i;
                TL_DECIDE: done_o = bit_i && (CID_LEN == 1);
                TL_CID: begin
                    err_o  = !bit_i;
                    done_o = bit_i && (cid_q == CW'(CID_LEN - 1));
                end
                default: ;
            endcase
        end
    end

    // Advance through the tail phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st_q  <= TL_FES_HI;
            cid_q <= '0;
            dyn_q <= 1'b0;
        end else if (take) begin
            case (st_q)
                TL_FES_HI: st_q <= TL_FES_LO;
                TL_FES_LO: st_q <= TL_DECIDE;
                TL_DECIDE: begin
                    if (bit_i) begin
                        cid_q <= CW'(1);
                        st_q  <= TL_CID;
                    end else begin
                        dyn_q <= 1'b1;
                        st_q  <= TL_DTS;
                    end
                end
                TL_DTS: begin
                    if (bit_i) begin
                        cid_q <= '0;
                        st_q  <= TL_CID;
                    end
                end
                TL_CID:  cid_q <= cid_q + CW'(1);
                default: st_q <= TL_FES_HI;
            endcase
        end
    end
endmodule

// File: rtl/tt_frame_rx.sv
// Frame receiver for a time-triggered bus. Consumes already-timed bits,
// finds the start sequence, de-frames bytes, parses header, payload and
// trailer, then checks the tail. Assumes bit_vld_i pulses once per bus bit.
module tt_frame_rx #(
    parameter int BYTE_W  = 8,
    parameter int ID_W    = 11,
    parameter int LEN_W   = 7,
    parameter int HCRC_W  = 11,
    parameter int CYC_W   = 6,
    parameter int CRC_W   = 24,
    parameter int CID_LEN = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    output logic              hdr_vld_o,
    output logic              rsv_o,
    output logic              ppi_o,
    output logic              null_frame_o,
    output logic              sync_o,
    output logic              startup_o,
    output logic [ID_W-1:0]   frame_id_o,
    output logic [LEN_W-1:0]  pay_words_o,
    output logic [HCRC_W-1:0] hdr_crc_o,
    output logic [CYC_W-1:0]  cycle_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              trl_vld_o,
    output logic [CRC_W-1:0]  frame_crc_o,
    output logic              frame_done_o,
    output logic              dynamic_o,
    output logic              cas_o,
    output logic              proto_err_o
);
    import frx_pkg::*;

    localparam int HDR_W     = 5 + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int HDR_BYTES = HDR_W / BYTE_W;
    localparam int TRL_BYTES = CRC_W / BYTE_W;
    localparam int PAY_CW    = LEN_W + 1;

    rx_state_e state_q;
    phase_e    phase_q;
    logic [PAY_CW-1:0]       idx_q;
    logic [PAY_CW-1:0]       pay_n_q;
    logic [HDR_W-BYTE_W-1:0] hdr_q;
    logic [CRC_W-BYTE_W-1:0] crc_q;

    logic              strip_en, strip_done, strip_err;
    logic [BYTE_W-1:0] strip_byte;
    logic [HDR_W-1:0]  hdr_next;
    logic [CRC_W-1:0]  crc_next;
    logic              tail_en, tail_done, tail_err, tail_dyn;

    logic              u_rsv, u_ppi, u_nf, u_sync, u_stup, u_rule_err;
    logic [ID_W-1:0]   u_id;
    logic [LEN_W-1:0]  u_len;
    logic [HCRC_W-1:0] u_hcrc;
    logic [CYC_W-1:0]  u_cyc;

    // Sub-block enables and the next header and trailer words.
    always_comb begin
        strip_en = (state_q == RX_BYTES);
        tail_en  = (state_q == RX_TAIL);
        hdr_next = {hdr_q, strip_byte};
        crc_next = {crc_q, strip_byte};
    end

    frx_bss_strip #(.BYTE_W(BYTE_W)) strip_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (strip_en),
        .bit_vld_i  (bit_vld_i),
        .bit_i      (bit_i),
        .byte_done_o(strip_done),
        .byte_o     (strip_byte),
        .bss_err_o  (strip_err)
    );

    frx_hdr_unpack #(
        .ID_W(ID_W), .LEN_W(LEN_W), .HCRC_W(HCRC_W), .CYC_W(CYC_W)
    ) unpack_i (
        .hdr_i     (hdr_next),
        .rsv_o     (u_rsv),
        .ppi_o     (u_ppi),
        .nf_o      (u_nf),
        .sync_o    (u_sync),
        .stup_o    (u_stup),
        .id_o      (u_id),
        .len_o     (u_len),
        .hcrc_o    (u_hcrc),
        .cyc_o     (u_cyc),
        .rule_err_o(u_rule_err)
    );

    frx_tail_seq #(.CID_LEN(CID_LEN)) tail_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tail_en),
        .bit_vld_i(bit_vld_i),
        .bit_i    (bit_i),
        .done_o   (tail_done),
        .err_o    (tail_err),
        .dyn_o    (tail_dyn)
    );

    // Frame-level sequencing, field capture and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RX_IDLE;
            phase_q      <= PH_HDR;
            idx_q        <= '0;
            pay_n_q      <= '0;
            hdr_q        <= '0;
            crc_q        <= '0;
            hdr_vld_o    <= 1'b0;
            rsv_o        <= 1'b0;
            ppi_o        <= 1'b0;
            null_frame_o <= 1'b0;
            sync_o       <= 1'b0;
            startup_o    <= 1'b0;
            frame_id_o   <= '0;
            pay_words_o  <= '0;
            hdr_crc_o    <= '0;
            cycle_o      <= '0;
            byte_vld_o   <= 1'b0;
            byte_o       <= '0;
            trl_vld_o    <= 1'b0;
            frame_crc_o  <= '0;
            frame_done_o <= 1'b0;
            dynamic_o    <= 1'b0;
            cas_o        <= 1'b0;
            proto_err_o  <= 1'b0;
        end else begin
            hdr_vld_o    <= 1'b0;
            byte_vld_o   <= 1'b0;
            trl_vld_o    <= 1'b0;
            frame_done_o <= 1'b0;
            cas_o        <= 1'b0;
            proto_err_o  <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (bit_vld_i && !bit_i) begin
                        state_q <= RX_TSS;
                    end
                end
                RX_TSS: begin
                    if (bit_vld_i && bit_i) begin
                        state_q <= RX_BYTES;
                        phase_q <= PH_HDR;
                        idx_q   <= '0;
                    end
                end
                RX_BYTES: begin
                    if (strip_err) begin
                        if (phase_q == PH_HDR && idx_q == '0) begin
                            cas_o <= 1'b1;
                        end else begin
                            proto_err_o <= 1'b1;
                        end
                        state_q <= RX_IDLE;
                    end else if (strip_done) begin
                        case (phase_q)
                            PH_HDR: begin
                                hdr_q <= hdr_next[HDR_W-BYTE_W-1:0];
                                if (idx_q == PAY_CW'(HDR_BYTES - 1)) begin
                                    idx_q <= '0;
                                    if (u_rule_err) begin
                                        proto_err_o <= 1'b1;
                                        state_q     <= RX_IDLE;
                                    end else begin
                                        hdr_vld_o    <= 1'b1;
                                        rsv_o        <= u_rsv;
                                        ppi_o        <= u_ppi;
                                        null_frame_o <= ~u_nf;
                                        sync_o       <= u_sync;
                                        startup_o    <= u_stup;
                                        frame_id_o   <= u_id;
                                        pay_words_o  <= u_len;
                                        hdr_crc_o    <= u_hcrc;
                                        cycle_o      <= u_cyc;
                                        pay_n_q      <= {u_len, 1'b0};
                                        phase_q      <= (u_len == '0) ? PH_TRL : PH_PAY;
                                    end
                                end else begin
                                    idx_q <= idx_q + PAY_CW'(1);
                                end
                            end
                            PH_PAY: begin
                                byte_o     <= strip_byte;
                                byte_vld_o <= 1'b1;
                                if (idx_q == pay_n_q - PAY_CW'(1)) begin
                                    idx_q   <= '0;
                                    phase_q <= PH_TRL;
                                end else begin
                                    idx_q <= idx_q + PAY_CW'(1);
                                end
                            end
                            default: begin
                                crc_q <= crc_next[CRC_W-BYTE_W-1:0];
                                if (idx_q == PAY_CW'(TRL_BYTES - 1)) begin
                                    frame_crc_o <= crc_next;
                                    trl_vld_o   <= 1'b1;
                                    idx_q       <= '0;
                                    state_q     <= RX_TAIL;
                                end else begin
                                    idx_q <= idx_q + PAY_CW'(1);
                                end
                            end
                        endcase
                    end
                end
                RX_TAIL: begin
                    if (tail_err) begin
                        proto_err_o <= 1'b1;
                        state_q     <= RX_IDLE;
                    end else if (tail_done) begin
                        frame_done_o <= 1'b1;
                        dynamic_o    <= tail_dyn;
                        state_q      <= RX_IDLE;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frx_rx_chk.sv
// Property checker for tt_frame_rx, attached by bind below.
module frx_rx_chk #(
    parameter int ID_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bit_vld_i,
    input logic            hdr_vld_o,
    input logic            byte_vld_o,
    input logic            trl_vld_o,
    input logic            frame_done_o,
    input logic            cas_o,
    input logic            proto_err_o,
    input logic            sync_o,
    input logic            startup_o,
    input logic [ID_W-1:0] frame_id_o
);
    logic in_pay_q;
    logic seen_trl_q;
    logic [5:0] evt;

    // Gather all event pulses into one vector.
    always_comb evt = {hdr_vld_o, byte_vld_o, trl_vld_o, frame_done_o, cas_o, proto_err_o};

    // Track the frame section the outputs claim to be in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pay_q   <= 1'b0;
            seen_trl_q <= 1'b0;
        end else begin
            if (hdr_vld_o) in_pay_q <= 1'b1;
            else if (trl_vld_o || proto_err_o || cas_o) in_pay_q <= 1'b0;
            if (trl_vld_o) seen_trl_q <= 1'b1;
            else if (frame_done_o || proto_err_o || hdr_vld_o) seen_trl_q <= 1'b0;
        end
    end

    // R2
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(evt));
    // R3
    event_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) (evt != '0) |-> $past(bit_vld_i));
    // R3
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(frame_id_o) |-> hdr_vld_o);
    // R10
    id_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_vld_o |-> (frame_id_o != '0));
    // R10
    startup_sync_chk: assert property (@(posedge clk) disable iff (!rst_n) (hdr_vld_o && startup_o) |-> sync_o);
    // R5
    byte_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_vld_o |-> in_pay_q);
    // R8
    done_after_trl_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_done_o |-> seen_trl_q);
endmodule

bind tt_frame_rx frx_rx_chk #(.ID_W(ID_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld_i   (bit_vld_i),
    .hdr_vld_o   (hdr_vld_o),
    .byte_vld_o  (byte_vld_o),
    .trl_vld_o   (trl_vld_o),
    .frame_done_o(frame_done_o),
    .cas_o       (cas_o),
    .proto_err_o (proto_err_o),
    .sync_o      (sync_o),
    .startup_o   (startup_o),
    .frame_id_o  (frame_id_o)
);

// File: tb/tt_frame_rx_tb_top.sv
`timescale 1ns/1ps
module tt_frame_rx_tb_top;
    typedef struct packed {
        logic [10:0] id;
        logic [6:0]  words;
        logic        ppi;
        logic        nf;
        logic        sync;
        logic        stup;
        logic [5:0]  cyc;
        logic        dyn;
        logic [3:0]  dts;
        logic        bad;
        logic [3:0]  tss;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{id:11'd5,    words:7'd2, ppi:1'b0, nf:1'b1, sync:1'b1, stup:1'b1, cyc:6'd0,  dyn:1'b0, dts:4'd0, bad:1'b0, tss:4'd3},
        '{id:11'd2047, words:7'd0, ppi:1'b0, nf:1'b0, sync:1'b0, stup:1'b0, cyc:6'd63, dyn:1'b1, dts:4'd3, bad:1'b0, tss:4'd1},
        '{id:11'd1,    words:7'd1, ppi:1'b1, nf:1'b1, sync:1'b1, stup:1'b0, cyc:6'd21, dyn:1'b1, dts:4'd1, bad:1'b0, tss:4'd5},
        '{id:11'd0,    words:7'd1, ppi:1'b0, nf:1'b1, sync:1'b1, stup:1'b0, cyc:6'd7,  dyn:1'b0, dts:4'd0, bad:1'b1, tss:4'd2},
        '{id:11'd9,    words:7'd1, ppi:1'b0, nf:1'b1, sync:1'b0, stup:1'b1, cyc:6'd9,  dyn:1'b0, dts:4'd0, bad:1'b1, tss:4'd2},
        '{id:11'd1000, words:7'd3, ppi:1'b1, nf:1'b1, sync:1'b0, stup:1'b0, cyc:6'd42, dyn:1'b0, dts:4'd0, bad:1'b0, tss:4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld_i = 1'b0;
    logic bit_i = 1'b1;
    logic mon_clr = 1'b0;

    logic hdr_vld_o, rsv_o, ppi_o, null_frame_o, sync_o, startup_o;
    logic [10:0] frame_id_o;
    logic [6:0]  pay_words_o;
    logic [10:0] hdr_crc_o;
    logic [5:0]  cycle_o;
    logic        byte_vld_o;
    logic [7:0]  byte_o;
    logic        trl_vld_o;
    logic [23:0] frame_crc_o;
    logic        frame_done_o, dynamic_o, cas_o, proto_err_o;

    int n_chk = 0;
    int n_err = 0;
    int hdr_cnt, trl_cnt, done_cnt, cas_cnt, err_cnt, rx_cnt;
    logic [7:0] rx_bytes [0:255];

    always #4 clk = ~clk;

    tt_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
        .hdr_vld_o(hdr_vld_o), .rsv_o(rsv_o), .ppi_o(ppi_o), .null_frame_o(null_frame_o),
        .sync_o(sync_o), .startup_o(startup_o), .frame_id_o(frame_id_o),
        .pay_words_o(pay_words_o), .hdr_crc_o(hdr_crc_o), .cycle_o(cycle_o),
        .byte_vld_o(byte_vld_o), .byte_o(byte_o), .trl_vld_o(trl_vld_o),
        .frame_crc_o(frame_crc_o), .frame_done_o(frame_done_o), .dynamic_o(dynamic_o),
        .cas_o(cas_o), .proto_err_o(proto_err_o)
    );

    // Event monitor, sampling between clock edges.
    always @(negedge clk) begin
        if (mon_clr) begin
            hdr_cnt = 0; trl_cnt = 0; done_cnt = 0; cas_cnt = 0; err_cnt = 0; rx_cnt = 0;
        end else begin
            if (byte_vld_o) begin
                if (rx_cnt < 256) rx_bytes[rx_cnt] = byte_o;
                rx_cnt = rx_cnt + 1;
            end
            if (hdr_vld_o)    hdr_cnt  = hdr_cnt + 1;
            if (trl_vld_o)    trl_cnt  = trl_cnt + 1;
            if (frame_done_o) done_cnt = done_cnt + 1;
            if (cas_o)        cas_cnt  = cas_cnt + 1;
            if (proto_err_o)  err_cnt  = err_cnt + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld_i = 1'b1; bit_i = b;
        @(negedge clk); bit_vld_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
    endtask

    function automatic logic [10:0] hcrc_of(input vec_t v);
        return v.id ^ {v.words, 4'h9};
    endfunction

    function automatic logic [7:0] pay_byte(input vec_t v, input int k);
        return 8'(k * 29 + int'(v.id[7:0]) + 3);
    endfunction

    function automatic logic [23:0] crc_of(input vec_t v);
        return {v.id, v.words, v.cyc};
    endfunction

    // Build one frame bit by bit; optional faults in the tail.
    task automatic send_frame(input vec_t v, input int cid_n, input bit fes_bad, input bit cid_break);
        logic [39:0] hdr;
        logic [23:0] crc;
        hdr = {1'b0, v.ppi, v.nf, v.sync, v.stup, v.id, v.words, hcrc_of(v), v.cyc};
        crc = crc_of(v);
        for (int i = 0; i < int'(v.tss); i++) send_bit(1'b0);
        send_bit(1'b1);
        for (int b = 0; b < 5; b++) send_byte(hdr[39 - 8*b -: 8]);
        if (v.bad) return;
        for (int k = 0; k < 2 * int'(v.words); k++) send_byte(pay_byte(v, k));
        for (int b = 0; b < 3; b++) send_byte(crc[23 - 8*b -: 8]);
        send_bit(1'b1);
        send_bit(fes_bad ? 1'b1 : 1'b0);
        if (fes_bad) return;
        if (v.dyn) begin
            for (int i = 0; i < int'(v.dts); i++) send_bit(1'b0);
            send_bit(1'b1);
        end
        for (int c = 0; c < cid_n; c++) send_bit((cid_break && c == 4) ? 1'b0 : 1'b1);
    endtask

    task automatic check_vec(input vec_t v);
        int mism;
        chk(hdr_cnt == (v.bad ? 0 : 1), "R3", "header pulses", hdr_cnt, v.bad ? 0 : 1);
        chk(err_cnt == (v.bad ? 1 : 0), "R10", "rule errors", err_cnt, v.bad ? 1 : 0);
        if (!v.bad) begin
            chk(frame_id_o == v.id, "R3", "frame id", frame_id_o, v.id);
            chk(pay_words_o == v.words, "R3", "words", pay_words_o, v.words);
            chk(hdr_crc_o == hcrc_of(v), "R3", "header crc", hdr_crc_o, hcrc_of(v));
            chk(cycle_o == v.cyc, "R3", "cycle", cycle_o, v.cyc);
            chk({rsv_o, ppi_o, sync_o, startup_o} == {1'b0, v.ppi, v.sync, v.stup}, "R3", "flags",
                {rsv_o, ppi_o, sync_o, startup_o}, {1'b0, v.ppi, v.sync, v.stup});
            chk(null_frame_o == !v.nf, "R4", "null flag", null_frame_o, !v.nf);
            chk(rx_cnt == 2 * int'(v.words), "R5", "byte count", rx_cnt, 2 * int'(v.words));
            mism = 0;
            for (int k = 0; k < 2 * int'(v.words) && k < rx_cnt; k++)
                if (rx_bytes[k] != pay_byte(v, k)) mism++;
            chk(mism == 0, "R5", "byte mismatches", mism, 0);
            chk(trl_cnt == 1 && frame_crc_o == crc_of(v), "R6", "trailer", frame_crc_o, crc_of(v));
            chk(done_cnt == 1, v.dyn ? "R9" : "R8", "done pulses", done_cnt, 1);
            chk(dynamic_o == v.dyn, v.dyn ? "R9" : "R8", "dynamic flag", dynamic_o, v.dyn);
        end
    endtask

    initial begin
        mon_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs are idle under reset
        chk({hdr_vld_o, byte_vld_o, trl_vld_o, frame_done_o, dynamic_o, cas_o, proto_err_o, frame_id_o, frame_crc_o} == '0,
            "R1", "reset outputs", frame_id_o, 0);
        rst_n = 1'b1;
        mon_clr = 1'b0;
        @(negedge clk);
        chk(frame_crc_o == '0 && byte_o == '0, "R1", "after reset", frame_crc_o, 0);

        // R2: high bits in idle are ignored
        clear_mon();
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        @(negedge clk);
        chk(hdr_cnt + cas_cnt + err_cnt + rx_cnt + done_cnt == 0, "R2", "idle events",
            hdr_cnt + cas_cnt + err_cnt + rx_cnt + done_cnt, 0);

        // Vector table walk
        for (int i = 0; i < 6; i++) begin
            clear_mon();
            send_frame(VECS[i], 11, 1'b0, 1'b0);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R7: start followed by 1,1,1 is a collision avoidance symbol
        clear_mon();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        @(negedge clk);
        chk(cas_cnt == 1 && hdr_cnt == 0, "R7", "cas 111", cas_cnt, 1);
        // R7: start followed by 1,0 (wrong first framing bit)
        clear_mon();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        @(negedge clk);
        chk(cas_cnt == 1 && err_cnt == 0, "R7", "cas 10", cas_cnt, 1);
        send_bit(1'b1);
        // R12: a full frame is accepted after the symbol
        clear_mon();
        send_frame(VECS[0], 11, 1'b0, 1'b0);
        @(negedge clk);
        chk(done_cnt == 1 && hdr_cnt == 1, "R12", "frame after cas", done_cnt, 1);

        // R11: bad framing bit on the second header byte
        clear_mon();
        send_bit(1'b0); send_bit(1'b1); send_byte(8'h00);
        send_bit(1'b1); send_bit(1'b1);
        @(negedge clk);
        chk(err_cnt == 1 && cas_cnt == 0, "R11", "mid-frame framing error", err_cnt, 1);

        // R11: wrong end marker
        clear_mon();
        send_frame(VECS[0], 11, 1'b1, 1'b0);
        @(negedge clk);
        chk(err_cnt == 1 && done_cnt == 0 && trl_cnt == 1, "R11", "bad end marker", err_cnt, 1);

        // R11: low bit inside the idle delimiter
        clear_mon();
        send_frame(VECS[0], 11, 1'b0, 1'b1);
        @(negedge clk);
        chk(err_cnt == 1 && done_cnt == 0, "R11", "broken delimiter", err_cnt, 1);

        // R8: static frame completes on the 11th delimiter bit, not the 10th
        clear_mon();
        send_frame(VECS[5], 10, 1'b0, 1'b0);
        @(negedge clk);
        chk(done_cnt == 0, "R8", "done after 10 bits", done_cnt, 0);
        send_bit(1'b1);
        @(negedge clk);
        chk(done_cnt == 1 && dynamic_o == 1'b0, "R8", "done after 11 bits", done_cnt, 1);

        // R9: dynamic frame delimiter counted after the trailing run
        clear_mon();
        send_frame(VECS[2], 10, 1'b0, 1'b0);
        @(negedge clk);
        chk(done_cnt == 0, "R9", "dynamic done early", done_cnt, 0);
        send_bit(1'b1);
        @(negedge clk);
        chk(done_cnt == 1 && dynamic_o == 1'b1, "R9", "dynamic done", dynamic_o, 1);

        // R1: reset in the middle of a frame, then R12 a clean frame
        send_bit(1'b0); send_bit(1'b1); send_byte(8'h00); send_byte(8'h55);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({hdr_vld_o, frame_done_o, dynamic_o, frame_id_o, frame_crc_o} == '0, "R1", "mid-frame reset",
            frame_id_o, 0);
        rst_n = 1'b1;
        clear_mon();
        send_frame(VECS[1], 11, 1'b0, 1'b0);
        @(negedge clk);
        chk(done_cnt == 1 && frame_id_o == 11'd2047, "R12", "frame after reset", frame_id_o, 2047);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule